// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address, a 14-bit video address bus and the cartridge memories. Software programs it one bit at a time. Each CPU write into the upper half of the address space pushes data bit 0 into a five-bit shift register. The fifth such write commits the collected value into one of four internal 5-bit registers: control, character bank low, character bank high and program select.

From those registers the block produces three addresses. The first is a banked program ROM address with a 32 KiB mode and two 16 KiB modes; each 16 KiB mode holds one window fixed. The second is a banked character address with one 8 KiB bank or two 4 KiB banks. The third is a nametable address with four mirroring arrangements. The block also gates an 8 KiB work-RAM window at 0x6000–0x7FFF.

A write with data bit 7 set aborts a partial sequence. The ROM, character memory and work RAM sit outside the block and are reached through plain address and strobe ports. Final addresses are cut to the configured port widths, so any bank number beyond the memory size wraps back into it.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the registers hold control=0x0C, character-low=0x00, character-high=0x01 and program-select=0x0F, and the shift count is zero. With these values, CPU 0x8000–0xFFFF maps to program bank 15, video 0x0000–0x1FFF maps straight through, and the nametable uses single-screen low.
- R2: A CPU write to 0x8000–0xFFFF with data bit 7 clear shifts data bit 0 into bit 4 of the shift value, which shifts right on each write. On the fifth write the value is stored into register cpu_addr[14:13] (0 control, 1 character-low, 2 character-high, 3 program-select). Fewer than five writes change no register.
- R3: A CPU write to 0x8000–0xFFFF with data bit 7 set clears the shift count and sets control bits 3 and 2. Control bits 4, 1 and 0 are kept.
- R4: control[1:0] picks the nametable address nt_addr[10:0]. The low 10 bits always pass through. Bit 10 comes from the mode: 0 gives 0, 1 gives 1, 2 gives vid_addr[10] and 3 gives vid_addr[11].
- R5: With control bit 3 clear, prg_addr = {program-select[3:1], cpu_addr[14:0]}, which is a 32 KiB bank with bit 0 ignored.
- R6: With control bit 3 set, each 16 KiB window of the program space is banked. If control bit 2 is set, 0x8000–0xBFFF uses bank program-select[3:0] and 0xC000–0xFFFF uses bank 15. If control bit 2 is clear, 0x8000–0xBFFF uses bank 0 and 0xC000–0xFFFF uses program-select[3:0]. In both cases prg_addr = {bank, cpu_addr[13:0]}.
- R7: With control bit 4 clear, chr_addr = {character-low, vid_addr[12:0]}.
- R8: With control bit 4 set, chr_addr = {character-low, vid_addr[11:0]} when vid_addr[12] is 0, and {character-high, vid_addr[11:0]} when it is 1.
- R9: With program-select bit 4 set, CPU reads in 0x6000–0xFFFF's work-RAM window 0x6000–0x7FFF return 0x00 and wram_we stays low. With the bit clear, reads there return wram_rdata and writes raise wram_we. Reads at 0x8000–0xFFFF return prg_rdata, and reads below 0x6000 return 0x00.
- R10: chr_we follows vid_we for video 0x0000–0x1FFF only when CHR_IS_RAM is 1, and is otherwise always low. nt_we follows vid_we for 0x2000–0x3EFF and stays low for 0x3F00–0x3FFF.
- R11: prg_addr and chr_addr are the low PRG_AW and CHR_AW bits of the full 18-bit bank address, so oversize bank numbers alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | CPU read data |
| prg_addr | output | PRG_AW | Program ROM address |
| prg_rdata | input | 8 | Program ROM data |
| wram_addr | output | 13 | Work-RAM address |
| wram_wdata | output | 8 | Work-RAM write data |
| wram_we | output | 1 | Work-RAM write enable |
| wram_rdata | input | 8 | Work-RAM read data |
| vid_addr | input | 14 | Video bus address |
| vid_we | input | 1 | Video bus write strobe |
| chr_addr | output | CHR_AW | Character memory address |
| chr_we | output | 1 | Character memory write enable |
| nt_addr | output | 11 | Nametable RAM address |
| nt_we | output | 1 | Nametable RAM write enable |

## Verification
Random register loads, each a serial sequence of five writes, are sometimes preceded by a few stray bits and a bit-7 abort. After each load, random addresses in both program windows, both pattern halves and all four nametable quadrants are compared with a reference model.

A load of four bits followed by a check exposes early commits. A load after an abort exposes a counter that fails to clear. Walking the four mirroring modes shows whether bit 10 comes from address bit 10 or bit 11.

A second instance with narrow memories and ROM character storage separates wrap-around and the write gating from the main mapping.

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper #(
  parameter int PRG_AW     = 18,
  parameter int CHR_AW     = 17,
  parameter bit CHR_IS_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [7:0]        cpu_rdata,
  output logic [PRG_AW-1:0] prg_addr,
  input  logic [7:0]        prg_rdata,
  output logic [12:0]       wram_addr,
  output logic [7:0]        wram_wdata,
  output logic              wram_we,
  input  logic [7:0]        wram_rdata,
  input  logic [13:0]       vid_addr,
  input  logic              vid_we,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_we,
  output logic [10:0]       nt_addr,
  output logic              nt_we
);
  localparam int SR_W     = 5;
  localparam int CNT_W    = $clog2(SR_W + 1);
  localparam int PBANK_W  = 4;
  localparam int PRG_FULL = PBANK_W + 14;
  localparam int CHR_FULL = SR_W + 13;
  localparam logic [SR_W-1:0] CTRL_RST = 5'h0C;
  localparam logic [SR_W-1:0] CLO_RST  = 5'h00;
  localparam logic [SR_W-1:0] CHI_RST  = 5'h01;
  localparam logic [SR_W-1:0] PSEL_RST = 5'h0F;

  logic [SR_W-1:0]  ctrl, chr_lo, chr_hi, prg_sel, sh_val;
  logic [CNT_W-1:0] sh_cnt;

  wire              map_wr  = cpu_we & cpu_addr[15];
  wire [SR_W-1:0]   sh_next = {cpu_wdata[0], sh_val[SR_W-1:1]};
  wire              sh_last = (sh_cnt == CNT_W'(SR_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST;
      chr_lo  <= CLO_RST;
      chr_hi  <= CHI_RST;
      prg_sel <= PSEL_RST;
      sh_val  <= '0;
      sh_cnt  <= '0;
    end else if (map_wr) begin
      if (cpu_wdata[7]) begin
        sh_cnt <= '0;
        ctrl   <= ctrl | 5'h0C;
      end else begin
        sh_val <= sh_next;
        if (sh_last) begin
          sh_cnt <= '0;
          case (cpu_addr[14:13])
            2'd0:    ctrl    <= sh_next;
            2'd1:    chr_lo  <= sh_next;
            2'd2:    chr_hi  <= sh_next;
            default: prg_sel <= sh_next;
          endcase
        end else begin
          sh_cnt <= sh_cnt + 1'b1;
        end
      end
    end
  end

  logic [PBANK_W-1:0] pbank;
  always_comb begin
    if (!ctrl[3])
      pbank = {prg_sel[3:1], cpu_addr[14]};
    else if (ctrl[2])
      pbank = cpu_addr[14] ? {PBANK_W{1'b1}} : prg_sel[PBANK_W-1:0];
    else
      pbank = cpu_addr[14] ? prg_sel[PBANK_W-1:0] : '0;
  end
  wire [PRG_FULL-1:0] prg_full = {pbank, cpu_addr[13:0]};
  assign prg_addr = PRG_AW'(prg_full);

  logic [CHR_FULL-1:0] chr_full;
  always_comb begin
    if (ctrl[4])
      chr_full = {1'b0, (vid_addr[12] ? chr_hi : chr_lo), vid_addr[11:0]};
    else
      chr_full = {chr_lo, vid_addr[12:0]};
  end
  assign chr_addr = CHR_AW'(chr_full);

  logic nt_page;
  always_comb begin
    case (ctrl[1:0])
      2'd0:    nt_page = 1'b0;
      2'd1:    nt_page = 1'b1;
      2'd2:    nt_page = vid_addr[10];
      default: nt_page = vid_addr[11];
    endcase
  end
  assign nt_addr = {nt_page, vid_addr[9:0]};

  assign chr_we = CHR_IS_RAM & vid_we & ~vid_addr[13];
  assign nt_we  = vid_we & vid_addr[13] & (vid_addr[13:8] != 6'h3F);

  wire wram_hit = (cpu_addr[15:13] == 3'b011);
  assign wram_addr  = cpu_addr[12:0];
  assign wram_wdata = cpu_wdata;
  assign wram_we    = cpu_we & wram_hit & ~prg_sel[4];

  always_comb begin
    if (wram_hit)
      cpu_rdata = prg_sel[4] ? 8'h00 : wram_rdata;
    else if (cpu_addr[15])
      cpu_rdata = prg_rdata;
    else
      cpu_rdata = 8'h00;
  end
endmodule

// File: rtl/serial_bank_mapper_chk.sv
module serial_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic [7:0]  cpu_rdata,
  input logic        wram_we,
  input logic [13:0] vid_addr,
  input logic        vid_we,
  input logic        chr_we,
  input logic [4:0]  ctrl,
  input logic [4:0]  prg_sel,
  input logic [2:0]  sh_cnt
);
  wire esc_wr  = cpu_we && cpu_addr[15] && cpu_wdata[7];
  wire bit_wr  = cpu_we && cpu_addr[15] && !cpu_wdata[7];

  assert_escape_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    esc_wr |=> (ctrl[3:2] == 2'b11 && sh_cnt == 3'd0));

  assert_escape_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    esc_wr |=> (ctrl[4] == $past(ctrl[4]) && ctrl[1:0] == $past(ctrl[1:0])));

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_cnt <= 3'd4);

  assert_commit_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && sh_cnt == 3'd4) |=> sh_cnt == 3'd0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> ($stable(ctrl) && $stable(prg_sel)));

  assert_wram_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prg_sel[4] |-> (!wram_we && (cpu_addr[15:13] != 3'b011 || cpu_rdata == 8'h00)));

  assert_chr_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> (vid_we && !vid_addr[13]));
endmodule

bind serial_bank_mapper serial_bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .wram_we(wram_we),
  .vid_addr(vid_addr), .vid_we(vid_we), .chr_we(chr_we),
  .ctrl(ctrl), .prg_sel(prg_sel), .sh_cnt(sh_cnt)
);

// File: tb/sim_serial_bank_mapper.sv
module sim_serial_bank_mapper;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] vid_addr = '0;
  logic        vid_we = 1'b0;
  logic [7:0]  prg_rdata = 8'hA5, wram_rdata = 8'h3C;

  logic [7:0]  cpu_rdata, wram_wdata, u1_rdata, u1_wwd;
  logic [17:0] prg_addr;
  logic [16:0] chr_addr;
  logic [12:0] wram_addr, u1_waddr;
  logic        wram_we, chr_we, nt_we, u1_wwe, u1_chr_we, u1_nt_we;
  logic [10:0] nt_addr, u1_nt;
  logic [15:0] u1_prg;
  logic [12:0] u1_chr;

  always #(CLK_P/2) clk = ~clk;

  serial_bank_mapper #(.PRG_AW(18), .CHR_AW(17), .CHR_IS_RAM(1'b1)) u0 (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_we, .cpu_rdata, .prg_addr, .prg_rdata,
    .wram_addr, .wram_wdata, .wram_we, .wram_rdata, .vid_addr, .vid_we,
    .chr_addr, .chr_we, .nt_addr, .nt_we);

  serial_bank_mapper #(.PRG_AW(16), .CHR_AW(13), .CHR_IS_RAM(1'b0)) u1 (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_we, .cpu_rdata(u1_rdata),
    .prg_addr(u1_prg), .prg_rdata, .wram_addr(u1_waddr), .wram_wdata(u1_wwd),
    .wram_we(u1_wwe), .wram_rdata, .vid_addr, .vid_we, .chr_addr(u1_chr),
    .chr_we(u1_chr_we), .nt_addr(u1_nt), .nt_we(u1_nt_we));

  int checks = 0, errors = 0;
  logic [4:0] mr [4];
  logic [4:0] msh;
  int mcnt;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_prg(logic [15:0] a);
    logic [3:0] b;
    if (!mr[0][3]) b = {mr[3][3:1], a[14]};
    else if (mr[0][2]) b = a[14] ? 4'hF : mr[3][3:0];
    else b = a[14] ? mr[3][3:0] : 4'h0;
    return {b, a[13:0]};
  endfunction

  function automatic logic [17:0] exp_chr(logic [13:0] v);
    if (mr[0][4]) return {1'b0, (v[12] ? mr[2] : mr[1]), v[11:0]};
    return {mr[1], v[12:0]};
  endfunction

  function automatic logic [10:0] exp_nt(logic [13:0] v);
    case (mr[0][1:0])
      2'd0: return {1'b0, v[9:0]};
      2'd1: return {1'b1, v[9:0]};
      2'd2: return {v[10], v[9:0]};
      default: return {v[11], v[9:0]};
    endcase
  endfunction

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk);
    #1 cpu_we = 1'b0;
    if (a[15]) begin
      if (d[7]) begin
        mcnt = 0; mr[0] = mr[0] | 5'h0C;
      end else begin
        msh = {d[0], msh[4:1]};
        mcnt++;
        if (mcnt == 5) begin mr[a[14:13]] = msh; mcnt = 0; end
      end
    end
  endtask

  task automatic load(int idx, logic [4:0] v, int nbits);
    for (int i = 0; i < nbits; i++)
      cpu_wr({1'b1, 2'(idx), 13'($urandom)}, {1'b0, 6'($urandom), v[i]});
  endtask

  task automatic check_maps();
    logic [15:0] a;
    logic [13:0] v;
    logic [17:0] ep, ec;
    a = {1'b1, 15'($urandom)};
    cpu_addr = a; #2;
    ep = exp_prg(a);
    chk(mr[0][3] ? "R6 prg 16K" : "R5 prg 32K", 32'(prg_addr), 32'(ep));
    chk("R11 prg wrap", 32'(u1_prg), 32'(ep[15:0]));
    v = {1'b0, 13'($urandom)};
    vid_addr = v; #2;
    ec = exp_chr(v);
    chk(mr[0][4] ? "R8 chr 4K" : "R7 chr 8K", 32'(chr_addr), 32'(ec[16:0]));
    chk("R11 chr wrap", 32'(u1_chr), 32'(ec[12:0]));
    v = {2'b10, 12'($urandom)};
    vid_addr = v; #2;
    chk("R4 mirror", 32'(nt_addr), 32'(exp_nt(v)));
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    mr[0] = 5'h0C; mr[1] = 5'h00; mr[2] = 5'h01; mr[3] = 5'h0F;
    msh = '0; mcnt = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R1 reset state
    cpu_addr = 16'h8123; #2; chk("R1 prg low window", 32'(prg_addr), 32'h3C123);
    cpu_addr = 16'hC456; #2; chk("R1 prg high window", 32'(prg_addr), 32'h3C456);
    vid_addr = 14'h1456; #2; chk("R1 chr", 32'(chr_addr), 32'h01456);
    vid_addr = 14'h2C12; #2; chk("R1 nametable", 32'(nt_addr), 32'h012);
    cpu_addr = 16'h6000; #2; chk("R1 wram on", 32'(cpu_rdata), 32'h3C);

    // R9 read decode
    cpu_addr = 16'h8000; #2; chk("R9 rom read", 32'(cpu_rdata), 32'hA5);
    cpu_addr = 16'h4000; #2; chk("R9 low read", 32'(cpu_rdata), 32'h00);

    // R2 four bits do nothing, fifth commits
    load(0, 5'h03, 4);
    vid_addr = 14'h2800; #2; chk("R2 no early commit", 32'(nt_addr), 32'h000);
    load(0, 5'h03, 1);
    vid_addr = 14'h2800; #2; chk("R2 commit ctrl", 32'(nt_addr), 32'h400);

    // R3 escape mid-sequence then load program select
    load(3, 5'h1F, 2);
    cpu_wr(16'hA000, 8'h80);
    load(3, 5'h05, 5);
    cpu_addr = 16'h8010; #2; chk("R3 counter cleared", 32'(prg_addr), 32'h14010);
    vid_addr = 14'h2800; #2; chk("R3 mirror kept", 32'(nt_addr), 32'h400);

    // R4 all mirroring modes
    for (int m = 0; m < 4; m++) begin
      load(0, {3'b011, 2'(m)}, 5);
      for (int q = 0; q < 4; q++) begin
        vid_addr = {2'b10, 2'(q), 10'h155}; #2;
        chk("R4 mode", 32'(nt_addr), 32'(exp_nt(vid_addr)));
      end
    end

    // R9 gating
    @(negedge clk); cpu_addr = 16'h6010; cpu_we = 1'b1; #2;
    chk("R9 wram write on", 32'(wram_we), 32'h1);
    @(posedge clk); #1 cpu_we = 1'b0;
    load(3, 5'h12, 5);
    @(negedge clk); cpu_addr = 16'h7FF0; cpu_we = 1'b1; #2;
    chk("R9 wram write off", 32'(wram_we), 32'h0);
    chk("R9 wram read off", 32'(cpu_rdata), 32'h00);
    @(posedge clk); #1 cpu_we = 1'b0;

    // R10 write gating
    vid_we = 1'b1; vid_addr = 14'h0100; #2;
    chk("R10 chr ram write", 32'(chr_we), 32'h1);
    chk("R10 chr rom blocked", 32'(u1_chr_we), 32'h0);
    vid_addr = 14'h2100; #2;
    chk("R10 no chr above", 32'(chr_we), 32'h0);
    chk("R10 nt write", 32'(nt_we), 32'h1);
    vid_addr = 14'h3F00; #2;
    chk("R10 palette excluded", 32'(nt_we), 32'h0);
    vid_we = 1'b0;

    // R11 oversize banks
    load(0, 5'h00, 5);
    load(1, 5'h1F, 5);
    vid_addr = 14'h1FFF; #2;
    chk("R11 chr alias", 32'(chr_addr), 32'h1FFFF);
    cpu_addr = 16'hC001; #2;
    chk("R11 prg alias", 32'(u1_prg), 32'(exp_prg(16'hC001) & 18'hFFFF));

    // random loads with occasional aborts
    for (int it = 0; it < 250; it++) begin
      if ($urandom_range(0, 5) == 0) begin
        load($urandom_range(0, 3), 5'($urandom), $urandom_range(0, 4));
        cpu_wr({1'b1, 15'($urandom)}, 8'h80 | 8'($urandom));
      end
      load($urandom_range(0, 3), 5'($urandom), 5);
      check_maps();
      check_maps();
    end

    summary();
  end
endmodule